// File: doc/BRIEF.md
# PHY bring-up and link monitor

This block takes an external Ethernet PHY through its power-on sequence and then looks after it over the two-wire management bus (MDC clock plus bidirectional MDIO data). After an active-high reset it holds the PHY's active-low reset pin low for a timed interval. It then releases the pin and waits a second settle interval before it declares the PHY ready. Both intervals are counted in clock cycles derived from the clock-frequency parameter. The management engine is kept in reset until that point.

Once ready, the block issues one Clause 22 write. This write turns off auto-negotiation on the PHY's serial link toward the MAC, while the copper side keeps negotiating. From then on the block sits idle until the PHY pulls its active-low interrupt line. It then reads the interrupt-status register, which clears the interrupt, and after that the status register. From the status register it updates a link-up flag and three one-hot speed flags. The interrupt line and MDIO input both pass through a two-stage synchronizer first. The MDIO pad itself sits outside the block, driven from `mdio_o` when `mdio_oe` is high.

Top module: `phy_bringup_monitor`

## Requirements
- R1: `phy_rst_n` is low while `rst` is high. After `rst` falls it stays low for exactly HOLD = (CLK_FREQ_HZ/1e6)*RST_HOLD_US clock edges. It then goes high and stays high until the next `rst`.
- R2: `ready` rises exactly SETTLE = (CLK_FREQ_HZ/1e6)*SETTLE_US edges after `phy_rst_n` rises. It is never high while `phy_rst_n` is low, and it stays high until `rst`.
- R3: Before `ready`, MDC is held low and `mdio_oe` is low.
- R4: The first frame after `ready` is a write. It consists of 64 bits sent MSB first: 32 ones, start 01, opcode 01, PHY_ADDR[4:0], CFG_REG[4:0], turnaround 10, CFG_DATA[15:0]. `mdio_o` changes only on MDC falling edges.
- R5: MDC high and low phases each last HALF = ceil(CLK_FREQ_HZ / (2*MDC_MAX_HZ)) clock cycles, so the MDC rate never exceeds MDC_MAX_HZ.
- R6: In a read frame, opcode 10 is used and `mdio_oe` is low for bits 46 to 63 (turnaround and data). The 16 data bits are sampled from the synchronized `mdio_i` at the MDC rising edge of bits 48 to 63, MSB first. They must be valid on `mdio_i` at least 3 cycles before that edge.
- R7: After the configuration write, no further frame is issued while `phy_int_n` stays high, and the link and speed flags stay 0.
- R8: While `phy_int_n` is low the block reads INT_REG and then STAT_REG, in that order, and then returns to idle.
- R9: After the STAT_REG read, `link_up` = bit 10 of the read data. If link is up, speed bits [15:14] decode as 1x → `speed_1000`, 01 → `speed_100`, 00 → `speed_10`, with exactly one flag high. If link is down, all speed flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mdio_i | input | 1 | MDIO data from the pad (asynchronous) |
| phy_int_n | input | 1 | PHY interrupt, active low (asynchronous) |
| phy_rst_n | output | 1 | PHY reset, active low |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO data toward the pad |
| mdio_oe | output | 1 | MDIO pad drive enable |
| ready | output | 1 | PHY reset and settle sequence complete |
| link_up | output | 1 | Link status from last status read |
| speed_10 | output | 1 | Link up at 10 Mb/s |
| speed_100 | output | 1 | Link up at 100 Mb/s |
| speed_1000 | output | 1 | Link up at 1000 Mb/s |

## Verification
The bench counts the exact edge on which the PHY reset releases and the edge on which ready rises, with shortened delays. An off-by-one counter would shift either edge by a cycle. It captures the configuration write bit for bit against an arithmetically built 64-bit word, so a swapped opcode, address or turnaround shows up directly. A PHY model answers reads only after the turnaround; a design that kept driving MDIO or sampled on the wrong edge would decode garbage speed flags. Interrupts then report every speed code, including the reserved 11 and a link-down word with speed bits set, which catches decoders that leave a stale flag or light two flags at once.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int PREAMBLE_W = 32;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int FRAME_W    = PREAMBLE_W + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
  localparam int TA_IDX     = FRAME_W - DATA_W - 2;
  localparam int DATA_IDX   = FRAME_W - DATA_W;

  localparam logic [1:0] ST_BITS = 2'b01;
  localparam logic [1:0] OP_WR   = 2'b01;
  localparam logic [1:0] OP_RD   = 2'b10;
  localparam logic [1:0] TA_WR   = 2'b10;

  typedef enum logic [2:0] {
    SQ_BOOT, SQ_CFG, SQ_CFG_WAIT, SQ_IDLE,
    SQ_INT, SQ_INT_WAIT, SQ_STAT, SQ_STAT_WAIT
  } seq_st_e;
endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= {STAGES{RST_VAL}};
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/pm_reset_seq.sv
module pm_reset_seq #(
  parameter int HOLD_CYC   = 16,
  parameter int SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  output logic phy_rst_n,
  output logic ready
);
  localparam int MAXC = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      phy_rst_n <= 1'b0;
      ready     <= 1'b0;
    end else if (!phy_rst_n) begin
      if (cnt == CW'(HOLD_CYC - 1)) begin
        cnt       <= '0;
        phy_rst_n <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (!ready) begin
      if (cnt == CW'(SETTLE_CYC - 1)) ready <= 1'b1;
      else                            cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pm_mdio_engine.sv
module pm_mdio_engine
  import phy_mgmt_pkg::*;
#(
  parameter int HALF_CYC = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_read,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mdi,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              mdc,
  output logic              mdo,
  output logic              oe
);
  localparam int HCW  = $clog2(HALF_CYC + 1);
  localparam int BITW = $clog2(FRAME_W);

  logic [FRAME_W-1:0] frame, sh;
  logic [HCW-1:0]     hc;
  logic [BITW-1:0]    bitn;
  logic               busy, rd_q;

  always_comb begin
    frame = {{PREAMBLE_W{1'b1}}, ST_BITS, (is_read ? OP_RD : OP_WR),
             phy_addr, reg_addr, TA_WR, (is_read ? {DATA_W{1'b0}} : wdata)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; rd_q <= 1'b0; done <= 1'b0;
      sh <= '0; hc <= '0; bitn <= '0; rdata <= '0;
      mdc <= 1'b0; mdo <= 1'b0; oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; rd_q <= is_read; sh <= frame;
          mdo <= frame[FRAME_W-1]; oe <= 1'b1; mdc <= 1'b0;
          hc <= '0; bitn <= '0;
        end
      end else if (hc == HCW'(HALF_CYC - 1)) begin
        hc <= '0;
        if (!mdc) begin
          mdc <= 1'b1;
          if (rd_q && bitn >= BITW'(DATA_IDX)) rdata <= {rdata[DATA_W-2:0], mdi};
        end else begin
          mdc <= 1'b0;
          if (bitn == BITW'(FRAME_W - 1)) begin
            busy <= 1'b0; done <= 1'b1; oe <= 1'b0; mdo <= 1'b0;
          end else begin
            bitn <= bitn + 1'b1;
            sh   <= sh << 1;
            mdo  <= sh[FRAME_W-2];
            if (rd_q && bitn == BITW'(TA_IDX - 1)) oe <= 1'b0;
          end
        end
      end else begin
        hc <= hc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/phy_bringup_monitor.sv
module phy_bringup_monitor
  import phy_mgmt_pkg::*;
#(
  parameter int                CLK_FREQ_HZ = 156_250_000,
  parameter int                RST_HOLD_US = 11_000,
  parameter int                SETTLE_US   = 11_000,
  parameter int                MDC_MAX_HZ  = 2_500_000,
  parameter logic [ADDR_W-1:0] PHY_ADDR    = 5'd7,
  parameter logic [ADDR_W-1:0] CFG_REG     = 5'd27,
  parameter logic [DATA_W-1:0] CFG_DATA    = 16'h9084,
  parameter logic [ADDR_W-1:0] INT_REG     = 5'd19,
  parameter logic [ADDR_W-1:0] STAT_REG    = 5'd17,
  parameter int                LINK_BIT    = 10,
  parameter int                SPD_HI      = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic mdio_i,
  input  logic phy_int_n,
  output logic phy_rst_n,
  output logic mdc,
  output logic mdio_o,
  output logic mdio_oe,
  output logic ready,
  output logic link_up,
  output logic speed_10,
  output logic speed_100,
  output logic speed_1000
);
  localparam int CYC_PER_US = CLK_FREQ_HZ / 1_000_000;
  localparam int HOLD_CYC   = CYC_PER_US * RST_HOLD_US;
  localparam int SETTLE_CYC = CYC_PER_US * SETTLE_US;
  localparam int HALF_CYC   = (CLK_FREQ_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);
  localparam int SPD_LO     = SPD_HI - 1;

  seq_st_e           st;
  logic [1:0]        sync_q;
  logic              mdi_s, irq_n_s;
  logic              eng_rst, eng_start, eng_read, eng_done;
  logic [ADDR_W-1:0] eng_reg;
  logic [DATA_W-1:0] eng_rdata;
  logic              unused_rd_bits;

  pm_sync #(.W(2), .STAGES(2), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst(rst), .d({mdio_i, phy_int_n}), .q(sync_q)
  );
  assign mdi_s   = sync_q[1];
  assign irq_n_s = sync_q[0];

  pm_reset_seq #(.HOLD_CYC(HOLD_CYC), .SETTLE_CYC(SETTLE_CYC)) u_rstseq (
    .clk(clk), .rst(rst), .phy_rst_n(phy_rst_n), .ready(ready)
  );

  assign eng_rst   = rst | ~ready;
  assign eng_start = (st == SQ_CFG) || (st == SQ_INT) || (st == SQ_STAT);
  assign eng_read  = (st != SQ_CFG);
  assign eng_reg   = (st == SQ_CFG) ? CFG_REG : ((st == SQ_INT) ? INT_REG : STAT_REG);

  pm_mdio_engine #(.HALF_CYC(HALF_CYC)) u_eng (
    .clk(clk), .rst(eng_rst), .start(eng_start), .is_read(eng_read),
    .phy_addr(PHY_ADDR), .reg_addr(eng_reg), .wdata(CFG_DATA), .mdi(mdi_s),
    .done(eng_done), .rdata(eng_rdata), .mdc(mdc), .mdo(mdio_o), .oe(mdio_oe)
  );

  assign unused_rd_bits = ^eng_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SQ_BOOT;
      link_up <= 1'b0; speed_10 <= 1'b0; speed_100 <= 1'b0; speed_1000 <= 1'b0;
    end else begin
      case (st)
        SQ_BOOT:     if (ready) st <= SQ_CFG;
        SQ_CFG:      st <= SQ_CFG_WAIT;
        SQ_CFG_WAIT: if (eng_done) st <= SQ_IDLE;
        SQ_IDLE:     if (!irq_n_s) st <= SQ_INT;
        SQ_INT:      st <= SQ_INT_WAIT;
        SQ_INT_WAIT: if (eng_done) st <= SQ_STAT;
        SQ_STAT:     st <= SQ_STAT_WAIT;
        SQ_STAT_WAIT: if (eng_done) begin
          st         <= SQ_IDLE;
          link_up    <= eng_rdata[LINK_BIT];
          speed_1000 <= eng_rdata[LINK_BIT] &  eng_rdata[SPD_HI];
          speed_100  <= eng_rdata[LINK_BIT] & ~eng_rdata[SPD_HI] &  eng_rdata[SPD_LO];
          speed_10   <= eng_rdata[LINK_BIT] & ~eng_rdata[SPD_HI] & ~eng_rdata[SPD_LO];
        end
        default:     st <= SQ_BOOT;
      endcase
    end
  end
endmodule

// File: rtl/pm_checker.sv
module pm_checker (
  input logic clk,
  input logic rst,
  input logic phy_rst_n,
  input logic ready,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic link_up,
  input logic speed_10,
  input logic speed_100,
  input logic speed_1000
);
  a_r1_rst_released_once: assert property (@(posedge clk) disable iff (rst)
    phy_rst_n |=> phy_rst_n);

  a_r2_not_ready_in_reset: assert property (@(posedge clk) disable iff (rst)
    !phy_rst_n |-> !ready);

  a_r2_ready_sticky: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  a_r3_bus_quiet: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (!mdio_oe && !mdc));

  a_r4_data_stable_high: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

  a_r9_one_speed: assert property (@(posedge clk) disable iff (rst)
    link_up |-> $onehot({speed_10, speed_100, speed_1000}));

  a_r9_no_speed_down: assert property (@(posedge clk) disable iff (rst)
    !link_up |-> ({speed_10, speed_100, speed_1000} == 3'b000));
endmodule

bind phy_bringup_monitor pm_checker u_chk (
  .clk(clk), .rst(rst), .phy_rst_n(phy_rst_n), .ready(ready), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe), .link_up(link_up), .speed_10(speed_10),
  .speed_100(speed_100), .speed_1000(speed_1000)
);

// File: tb/tb_phy_bringup_monitor.sv
`timescale 1ns/1ps
module tb_phy_bringup_monitor;
  localparam int CLK_HZ     = 10_000_000;
  localparam int HOLD_US    = 3;
  localparam int SET_US     = 4;
  localparam int MDC_HZ     = 1_000_000;
  localparam int HOLD_EXP   = (CLK_HZ / 1_000_000) * HOLD_US;
  localparam int SET_EXP    = (CLK_HZ / 1_000_000) * SET_US;
  localparam int HALF_EXP   = (CLK_HZ + 2 * MDC_HZ - 1) / (2 * MDC_HZ);
  localparam logic [4:0]  T_PHY  = 5'd9;
  localparam logic [4:0]  T_CFG  = 5'd27;
  localparam logic [15:0] T_DATA = 16'hA5C3;
  localparam logic [4:0]  T_INT  = 5'd19;
  localparam logic [4:0]  T_STAT = 5'd17;
  localparam logic [63:0] EXP_WR = {32'hFFFF_FFFF, 2'b01, 2'b01, T_PHY, T_CFG, 2'b10, T_DATA};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mdi = 1'b1;
  logic phy_int_n, phy_rst_n, mdc, mdio_o, mdio_oe, ready;
  logic link_up, speed_10, speed_100, speed_1000;

  int n_tests = 0, n_fail = 0;
  int cyc = 0, irq_raise = 0, irq_ack = 0;
  int bitn = 0, fr_cnt = 0, oe_bad = 0, early_act = 0, t0 = 0, rise_gap = 0;
  logic [63:0] cap = '0, resp = '0;
  logic        rd_cur = 1'b0;
  logic [15:0] stat_val = '0;
  logic [63:0] fr_raw [0:31];
  logic [4:0]  fr_reg [0:31];
  logic        fr_rd  [0:31];

  assign phy_int_n = (irq_raise == irq_ack);

  always #2.5 clk = ~clk;
  always @(negedge clk) cyc++;

  phy_bringup_monitor #(
    .CLK_FREQ_HZ(CLK_HZ), .RST_HOLD_US(HOLD_US), .SETTLE_US(SET_US), .MDC_MAX_HZ(MDC_HZ),
    .PHY_ADDR(T_PHY), .CFG_REG(T_CFG), .CFG_DATA(T_DATA), .INT_REG(T_INT), .STAT_REG(T_STAT)
  ) dut (
    .clk(clk), .rst(rst), .mdio_i(mdi), .phy_int_n(phy_int_n), .phy_rst_n(phy_rst_n),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .ready(ready), .link_up(link_up),
    .speed_10(speed_10), .speed_100(speed_100), .speed_1000(speed_1000)
  );

  // PHY model: capture on MDC rise, answer reads after the turnaround
  always @(posedge mdc) begin
    if (!ready) early_act++;
    if (fr_cnt == 0 && bitn == 0) t0 = cyc;
    if (fr_cnt == 0 && bitn == 1) rise_gap = cyc - t0;
    if (rd_cur && bitn >= 46 && mdio_oe) oe_bad++;
    cap = {cap[62:0], (mdio_oe ? mdio_o : 1'b0)};
    bitn++;
    if (bitn == 46) begin
      rd_cur = (cap[11:10] == 2'b10);
      resp   = {46'b0, 2'b10, (cap[4:0] == T_INT) ? 16'h0400 :
                              ((cap[4:0] == T_STAT) ? stat_val : 16'h0000)};
    end
    if (bitn == 64) begin
      if (fr_cnt < 32) begin
        fr_raw[fr_cnt] = cap;
        fr_reg[fr_cnt] = cap[22:18];
        fr_rd[fr_cnt]  = (cap[29:28] == 2'b10);
      end
      if (cap[29:28] == 2'b10 && cap[22:18] == T_INT && !phy_int_n) irq_ack++;
      fr_cnt++;
      bitn   = 0;
      rd_cur = 1'b0;
    end
  end

  always @(negedge mdc) begin
    #1;
    if (rd_cur && bitn >= 46 && bitn <= 63) mdi = resp[63 - bitn];
    else                                    mdi = 1'b1;
  end

  always @(posedge mdio_oe) if (!ready) early_act++;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_irq(input logic lk, input logic [1:0] spd);
    int base, k;
    logic e1000, e100, e10;
    base     = fr_cnt;
    stat_val = {spd, 3'b000, lk, 10'b0};
    e1000 = lk & spd[1];
    e100  = lk & ~spd[1] & spd[0];
    e10   = lk & ~spd[1] & ~spd[0];
    irq_raise++;
    k = 0;
    while (fr_cnt < base + 2 && k < 5000) begin @(negedge clk); k++; end
    repeat (30) @(negedge clk);
    chk(fr_cnt == base + 2, "R8", "frames per interrupt", fr_cnt - base, 2);
    chk(fr_rd[base] && fr_reg[base] == T_INT, "R8", "first read register", fr_reg[base], T_INT);
    chk(fr_rd[base+1] && fr_reg[base+1] == T_STAT, "R8", "second read register", fr_reg[base+1], T_STAT);
    chk(phy_int_n == 1'b1, "R8", "interrupt cleared", phy_int_n, 1);
    chk(link_up == lk, "R9", "link_up", link_up, lk);
    chk({speed_10, speed_100, speed_1000} == {e10, e100, e1000}, "R9", "speed flags",
        {speed_10, speed_100, speed_1000}, {e10, e100, e1000});
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n;
    repeat (5) @(negedge clk);
    chk(phy_rst_n == 1'b0, "R1", "phy_rst_n during rst", phy_rst_n, 0);
    chk(ready == 1'b0, "R2", "ready during rst", ready, 0);
    chk(!mdio_oe && !mdc, "R3", "bus idle during rst", {mdio_oe, mdc}, 0);
    chk({link_up, speed_10, speed_100, speed_1000} == 4'b0, "R9", "flags in reset",
        {link_up, speed_10, speed_100, speed_1000}, 0);

    rst = 1'b0;
    n = 0;
    while (!phy_rst_n && n < 1000) begin @(negedge clk); n++; end
    chk(n == HOLD_EXP, "R1", "reset hold edges", n, HOLD_EXP);
    while (!ready && n < 2000) begin @(negedge clk); n++; end
    chk(n == HOLD_EXP + SET_EXP, "R2", "ready edge", n, HOLD_EXP + SET_EXP);
    chk(early_act == 0, "R3", "bus activity before ready", early_act, 0);

    n = 0;
    while (fr_cnt < 1 && n < 3000) begin @(negedge clk); n++; end
    chk(fr_cnt >= 1, "R4", "config frame seen", fr_cnt, 1);
    chk(fr_raw[0] == EXP_WR, "R4", "config frame bits", fr_raw[0], EXP_WR);
    chk(!fr_rd[0], "R4", "config frame is write", fr_rd[0], 0);
    chk(rise_gap == 2 * HALF_EXP, "R5", "MDC period", rise_gap, 2 * HALF_EXP);

    repeat (1500) @(negedge clk);
    chk(fr_cnt == 1, "R7", "no frames without interrupt", fr_cnt, 1);
    chk({link_up, speed_10, speed_100, speed_1000} == 4'b0, "R7", "flags idle",
        {link_up, speed_10, speed_100, speed_1000}, 0);

    run_irq(1'b1, 2'b10);
    run_irq(1'b1, 2'b01);
    run_irq(1'b1, 2'b00);
    run_irq(1'b1, 2'b11);
    run_irq(1'b0, 2'b10);
    run_irq(1'b1, 2'b01);

    chk(oe_bad == 0, "R6", "oe during read turnaround/data", oe_bad, 0);
    chk(ready == 1'b1, "R2", "ready held", ready, 1);
    chk(phy_rst_n == 1'b1, "R1", "phy_rst_n held", phy_rst_n, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule